// File: doc/BRIEF.md
# Packet-Command PIO Read Sequencer

This block is the device side of a packet-command read performed in programmed I/O mode. The host sets a byte count limit, writes the PACKET opcode, and is then asked through DRQ for a 12-byte command block, supplied as six 16-bit writes to the data port. The block decodes a READ(10) block, fetches the requested 2048-byte logical blocks from an internal pattern source, and streams them back as 16-bit reads of the data port.

The transfer is cut into DRQ bursts, each no longer than the programmed limit. The device raises an interrupt before each burst and once more at completion. Between bursts it shows BSY for one cycle while it sizes the next burst. Malformed requests are aborted with ERR set and an abort flag in the error register. Reads return data one cycle after the read strobe.

Top module: `apkt_pio_seq`

## Requirements
- R1: After reset, status (offset 7) reads 0x40 (DRDY only) and irq is low.
- R2: Writing 0xA0 to offset 7 while idle clears ERR/abort and makes status read 0xC0 (BSY|DRDY) for one cycle, then 0x48 (DRQ|DRDY) while the packet is awaited.
- R3: The packet is six writes to offset 0, with byte 2k in bits 7:0 and byte 2k+1 in bits 15:8 of write k. Byte 0 is the opcode (0x28). Bytes 2..5 hold the LBA, most significant first. Bytes 7..8 hold the block count, most significant first.
- R4: The byte count limit is written as its low byte at offset 4 and its high byte at offset 5. An odd limit is reduced by one. Each burst carries min(limit, bytes left) bytes. Status reads 0xC0 in the cycle after a burst's final word when more data remains.
- R5: irq rises before every burst, and status reads 0x48 during a burst.
- R6: Data word k (0..1023) of block b is {b[5:0], k[9:0]}. Blocks are delivered in ascending order from the LBA.
- R7: After the final word, irq rises and status reads 0x40.
- R8: A status read clears irq.
- R9: A limit below 2 aborts the packet: irq rises, status reads 0x41, and the error register (offset 1) reads 0x04.
- R10: A packet opcode other than 0x28 aborts the packet in the same way as R9.
- R11: A block count of zero completes at once with irq, no burst, and status 0x40.
- R12: A command other than 0xA0 written while idle aborts at once, with irq, status 0x41 and error register 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the host never asserts rd_en and wr_en in the same cycle. They also assume the host writes the limit registers only while the device is idle, since a burst's length is checked against the limit held in the register. The bench drives one strobe per cycle and programs the limit before each PACKET opcode. It reads the data port only as many times as the current burst allows, and it reads status only after it has seen irq or at a burst boundary.

// File: rtl/apkt_pkg.sv
package apkt_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CMDBSY, S_PKT, S_DECODE, S_PREP, S_DATA
  } st_t;

  localparam logic [2:0] A_DATA   = 3'd0;
  localparam logic [2:0] A_ERR    = 3'd1;
  localparam logic [2:0] A_LIM_LO = 3'd4;
  localparam logic [2:0] A_LIM_HI = 3'd5;
  localparam logic [2:0] A_CMD    = 3'd7;

  localparam logic [7:0] OP_PACKET = 8'hA0;
  localparam logic [7:0] OP_READ10 = 8'h28;
endpackage

// File: rtl/apkt_cmd_capture.sv
module apkt_cmd_capture #(
  parameter int DATA_W    = 16,
  parameter int PKT_WORDS = 6,
  parameter int LBA_W     = 32,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              last,
  output logic [7:0]        opcode,
  output logic [LBA_W-1:0]  lba,
  output logic [CNT_W-1:0]  nblk
);
  localparam int IW = $clog2(PKT_WORDS);
  localparam logic [IW-1:0] LAST_IDX = IW'(PKT_WORDS - 1);

  logic [IW-1:0] cnt_q;

  assign last = wr && (cnt_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (wr) begin
      cnt_q <= cnt_q + IW'(1);
    end
  end

  // Byte 2k arrives in the low half of word k; multi-byte fields are MSB first.
  always_ff @(posedge clk) begin
    if (rst) begin
      opcode <= '0;
      lba    <= '0;
      nblk   <= '0;
    end else if (wr) begin
      case (cnt_q)
        IW'(0): opcode        <= wdata[7:0];
        IW'(1): lba[31:16]    <= {wdata[7:0], wdata[15:8]};
        IW'(2): lba[15:0]     <= {wdata[7:0], wdata[15:8]};
        IW'(3): nblk[15:8]    <= wdata[15:8];
        IW'(4): nblk[7:0]     <= wdata[7:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/apkt_burst_sizer.sv
module apkt_burst_sizer #(
  parameter int LIM_W = 16,
  parameter int REM_W = 26
) (
  input  logic [LIM_W-2:0] lim_half,
  input  logic [REM_W-1:0] rem,
  output logic             lim_ok,
  output logic [LIM_W-2:0] burst
);
  logic [REM_W-1:0] lim_wide;

  assign lim_wide = REM_W'(lim_half);
  assign lim_ok   = |lim_half;
  assign burst    = (rem < lim_wide) ? (LIM_W-1)'(rem) : lim_half;
endmodule

// File: rtl/apkt_block_src.sv
module apkt_block_src #(
  parameter int DATA_W = 16,
  parameter int WIDX_W = 10
) (
  input  logic [DATA_W-WIDX_W-1:0] blk_tag,
  input  logic [WIDX_W-1:0]        widx,
  output logic [DATA_W-1:0]        word
);
  assign word = {blk_tag, widx};
endmodule

// File: rtl/apkt_pio_seq.sv
module apkt_pio_seq #(
  parameter int DATA_W    = 16,
  parameter int BLK_BYTES = 2048,
  parameter int PKT_WORDS = 6,
  parameter int LBA_W     = 32,
  parameter int CNT_W     = 16,
  parameter int LIM_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  import apkt_pkg::*;

  localparam int BLK_WORDS = BLK_BYTES / 2;
  localparam int WIDX_W    = $clog2(BLK_WORDS);
  localparam int REM_W     = CNT_W + WIDX_W;
  localparam int BW        = LIM_W - 1;
  localparam int TAG_W     = DATA_W - WIDX_W;

  st_t              st_q;
  logic [LIM_W-1:0] lim_q;
  logic             err_q, abrt_q;
  logic [LBA_W-1:0] blk_q;
  logic [WIDX_W-1:0] widx_q;
  logic [REM_W-1:0] rem_q;
  logic [BW-1:0]    brst_q;

  logic             wr_cmd, rd_sts, pkt_wr, dat_rd;
  logic             pkt_last, lim_ok, cmd_ok, go_data, irq_set;
  logic [7:0]       opcode;
  logic [LBA_W-1:0] lba;
  logic [CNT_W-1:0] nblk;
  logic [BW-1:0]    burst;
  logic [DATA_W-1:0] src_word;
  logic             sts_bsy, sts_drq;
  logic [7:0]       status;

  assign wr_cmd = wr_en && (addr == A_CMD);
  assign rd_sts = rd_en && (addr == A_CMD);
  assign pkt_wr = wr_en && (addr == A_DATA) && (st_q == S_PKT);
  assign dat_rd = rd_en && (addr == A_DATA) && (st_q == S_DATA);

  apkt_cmd_capture #(
    .DATA_W(DATA_W), .PKT_WORDS(PKT_WORDS), .LBA_W(LBA_W), .CNT_W(CNT_W)
  ) u_cap (
    .clk(clk), .rst(rst), .clr(st_q == S_CMDBSY), .wr(pkt_wr), .wdata(wdata),
    .last(pkt_last), .opcode(opcode), .lba(lba), .nblk(nblk)
  );

  apkt_burst_sizer #(.LIM_W(LIM_W), .REM_W(REM_W)) u_size (
    .lim_half(lim_q[LIM_W-1:1]), .rem(rem_q), .lim_ok(lim_ok), .burst(burst)
  );

  apkt_block_src #(.DATA_W(DATA_W), .WIDX_W(WIDX_W)) u_src (
    .blk_tag(blk_q[TAG_W-1:0]), .widx(widx_q), .word(src_word)
  );

  assign cmd_ok  = (opcode == OP_READ10) && lim_ok;
  assign go_data = cmd_ok && (nblk != '0);

  // Interrupt sources: burst start, completion, and every abort.
  assign irq_set = ((st_q == S_DECODE) && !go_data)
                || (st_q == S_PREP)
                || (dat_rd && (brst_q == BW'(1)) && (rem_q == REM_W'(1)))
                || ((st_q == S_IDLE) && wr_cmd && (wdata[7:0] != OP_PACKET));

  assign sts_bsy = (st_q == S_CMDBSY) || (st_q == S_DECODE) || (st_q == S_PREP);
  assign sts_drq = (st_q == S_PKT) || (st_q == S_DATA);
  assign status  = {sts_bsy, 1'b1, 1'b0, 1'b0, sts_drq, 2'b00, err_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      lim_q  <= '0;
      err_q  <= 1'b0;
      abrt_q <= 1'b0;
      blk_q  <= '0;
      widx_q <= '0;
      rem_q  <= '0;
      brst_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (wr_en && (addr == A_LIM_LO)) lim_q[7:0]       <= wdata[7:0];
          if (wr_en && (addr == A_LIM_HI)) lim_q[LIM_W-1:8] <= wdata[LIM_W-9:0];
          if (wr_cmd) begin
            if (wdata[7:0] == OP_PACKET) begin
              st_q   <= S_CMDBSY;
              err_q  <= 1'b0;
              abrt_q <= 1'b0;
            end else begin
              err_q  <= 1'b1;
              abrt_q <= 1'b1;
            end
          end
        end
        S_CMDBSY: st_q <= S_PKT;
        S_PKT: if (pkt_last) st_q <= S_DECODE;
        S_DECODE: begin
          if (!cmd_ok) begin
            err_q  <= 1'b1;
            abrt_q <= 1'b1;
            st_q   <= S_IDLE;
          end else if (!go_data) begin
            st_q <= S_IDLE;
          end else begin
            blk_q  <= lba;
            widx_q <= '0;
            rem_q  <= REM_W'(nblk) << WIDX_W;
            st_q   <= S_PREP;
          end
        end
        S_PREP: begin
          brst_q <= burst;
          st_q   <= S_DATA;
        end
        S_DATA: begin
          if (dat_rd) begin
            widx_q <= widx_q + WIDX_W'(1);
            if (&widx_q) blk_q <= blk_q + LBA_W'(1);
            rem_q  <= rem_q - REM_W'(1);
            brst_q <= brst_q - BW'(1);
            if (brst_q == BW'(1)) st_q <= (rem_q == REM_W'(1)) ? S_IDLE : S_PREP;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq   <= 1'b0;
      rdata <= '0;
    end else begin
      irq <= (irq && !rd_sts) || irq_set;
      if (rd_en) begin
        case (addr)
          A_DATA:   rdata <= dat_rd ? src_word : '0;
          A_ERR:    rdata <= DATA_W'({abrt_q, 2'b00});
          A_LIM_LO: rdata <= DATA_W'(lim_q[7:0]);
          A_LIM_HI: rdata <= DATA_W'(lim_q[LIM_W-1:8]);
          A_CMD:    rdata <= DATA_W'(status);
          default:  rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/apkt_pio_chk.sv
module apkt_pio_chk (
  input logic          clk,
  input logic          rst,
  input apkt_pkg::st_t st,
  input logic          rd_en,
  input logic          wr_en,
  input logic [2:0]    addr,
  input logic [7:0]    cmd_byte,
  input logic          irq,
  input logic [14:0]   lim_half,
  input logic [14:0]   brst,
  input logic [25:0]   rem,
  input logic          err,
  input logic          abrt
);
  import apkt_pkg::*;

  // R2
  cmd_bsy_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && wr_en && addr == A_CMD && cmd_byte == OP_PACKET) |=> (st == S_CMDBSY));

  // R4
  burst_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_DATA) |-> (brst <= lim_half && brst != '0 && 26'(brst) <= rem));

  // R5
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (st == S_DATA || st == S_IDLE));

  // R7
  done_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_DATA && rd_en && addr == A_DATA && rem == 26'd1) |=> (irq && st == S_IDLE));

  // R8
  irq_rdclr_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_DATA && rd_en && addr == A_CMD) |=> !irq);

  // R9
  abrt_err_chk: assert property (@(posedge clk) disable iff (rst)
    abrt |-> err);
endmodule

bind apkt_pio_seq apkt_pio_chk u_chk (
  .clk(clk), .rst(rst), .st(st_q), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .cmd_byte(wdata[7:0]), .irq(irq), .lim_half(lim_q[15:1]), .brst(brst_q),
  .rem(rem_q), .err(err_q), .abrt(abrt_q)
);

// File: tb/sim_apkt_pio_seq.sv
module sim_apkt_pio_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  apkt_pio_seq u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(irq, req, int'(irq), 1);
  endtask

  task automatic send_pkt(input logic [7:0] op, input logic [31:0] lba, input logic [15:0] nb);
    wr(3'd0, {8'h00, op});
    wr(3'd0, {lba[23:16], lba[31:24]});
    wr(3'd0, {lba[7:0], lba[15:8]});
    wr(3'd0, {nb[15:8], 8'h00});
    wr(3'd0, {8'h00, nb[7:0]});
    wr(3'd0, 16'h0000);
  endtask

  task automatic start_pkt(input logic [15:0] lim);
    logic [15:0] s;
    wr(3'd4, {8'h00, lim[7:0]});
    wr(3'd5, {8'h00, lim[15:8]});
    wr(3'd7, 16'h00A0);
    rd(3'd7, s);
    chk(s[7:0] == 8'hC0, "R2 busy after PACKET", s, 8'hC0);
    rd(3'd7, s);
    chk(s[7:0] == 8'h48, "R2 packet request", s, 8'h48);
  endtask

  task automatic t_reset();
    logic [15:0] s;
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    rd(3'd7, s);
    chk(s[7:0] == 8'h40, "R1 status after reset", s, 8'h40);
  endtask

  // R3 R4 R5 R6 R7 R8: full transfer with burst boundaries
  task automatic t_xfer(input logic [31:0] lba, input logic [15:0] nb, input logic [15:0] lim);
    logic [15:0] s, d, e;
    int total, limw, g, bn, bad, bad_a, bad_e;
    start_pkt(lim);
    send_pkt(8'h28, lba, nb);
    total = int'(nb) * 1024;
    limw  = int'(lim) / 2;
    g = 0;
    while (g < total) begin
      wait_irq("R5 irq before burst");
      rd(3'd7, s);
      chk(s[7:0] == 8'h48, "R5 status in burst", s, 8'h48);
      chk(irq == 1'b0, "R8 status read clears irq", irq, 0);
      bn = (total - g < limw) ? total - g : limw;
      bad = 0; bad_a = 0; bad_e = 0;
      for (int i = 0; i < bn; i++) begin
        logic [31:0] b;
        int k;
        b = lba + 32'((g + i) / 1024);
        k = (g + i) % 1024;
        e = {b[5:0], 10'(k)};
        rd(3'd0, d);
        if (d != e) begin
          if (bad == 0) begin bad_a = int'(d); bad_e = int'(e); end
          bad++;
        end
      end
      chk(bad == 0, "R6 R3 burst data", bad_a, bad_e);
      g += bn;
      if (g < total) begin
        rd(3'd7, s);
        chk(s[7:0] == 8'hC0, "R4 burst ends at limit", s, 8'hC0);
      end
    end
    wait_irq("R7 completion irq");
    rd(3'd7, s);
    chk(s[7:0] == 8'h40, "R7 final status", s, 8'h40);
  endtask

  task automatic t_abort_pkt(input logic [7:0] op, input logic [15:0] lim, input string req);
    logic [15:0] s;
    start_pkt(lim);
    send_pkt(op, 32'd0, 16'd1);
    wait_irq(req);
    rd(3'd7, s);
    chk(s[7:0] == 8'h41, req, s, 8'h41);
    rd(3'd1, s);
    chk(s[7:0] == 8'h04, req, s, 8'h04);
  endtask

  task automatic t_zero_count();
    logic [15:0] s;
    start_pkt(16'd4096);
    send_pkt(8'h28, 32'd9, 16'd0);
    wait_irq("R11 zero count irq");
    rd(3'd7, s);
    chk(s[7:0] == 8'h40, "R11 zero count status", s, 8'h40);
  endtask

  task automatic t_bad_cmd();
    logic [15:0] s;
    wr(3'd7, 16'h00EC);
    wait_irq("R12 bad command irq");
    rd(3'd7, s);
    chk(s[7:0] == 8'h41, "R12 bad command status", s, 8'h41);
    rd(3'd1, s);
    chk(s[7:0] == 8'h04, "R12 bad command error reg", s, 8'h04);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_xfer(32'd3, 16'd1, 16'd5120);
    t_xfer(32'h0000_0010, 16'd3, 16'd5121);
    t_xfer(32'h0102_033F, 16'd1, 16'd1000);
    t_abort_pkt(8'h28, 16'd0, "R9 zero limit abort");
    t_abort_pkt(8'h28, 16'd1, "R9 limit one abort");
    t_abort_pkt(8'h12, 16'd4096, "R10 wrong opcode abort");
    t_zero_count();
    t_bad_cmd();
    t_xfer(32'd7, 16'd2, 16'd65535);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule